// File: doc/BRIEF.md
# Timing Pattern Output Controller

This block drives sixteen pattern pins, split into four groups of four, from an output data register. The output data register changes only on two occasions: software writes it directly, or a timer compare-match event copies a staged next-data value into it. Software loads the next pattern ahead of time through a simple register write port. The chosen timer event then moves that pattern onto the pins, so pin changes stay locked to timer timing.

Each group picks one of four timer channels as its trigger source and has its own non-overlap mode. In normal mode a group updates all of its enabled bits on compare match A. In non-overlap mode the group splits each update in two. On compare match A only the bits that are heading to 0 are copied. On compare match B only the bits that are heading to 1 are copied. This puts a dead time between one pin falling and another pin rising. A pin is driven only when its direction bit and its next-data-enable bit are both set. The timer is not part of the block: compare-match A and B pulses from each channel arrive as one-cycle inputs.

Top module: `tpo_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all registers are zero, `pin_oe` is 0 and `pin_out` is 0.
- R2: `pin_oe` bit i is 1 exactly when the direction bit i (address 3) and the next-data-enable bit i (address 2) are both 1.
- R3: A write to the output data register (address 1) appears on `pin_out` one clock later. Turning the pin drive on shows the output data register, not the next-data value.
- R4: A write to the next-data register (address 0) leaves `pin_out` unchanged until a trigger occurs.
- R5: With the group's non-overlap bit at 0, a pulse on `cmp_a` of the selected channel copies the group's enabled next-data bits into the output data register. A pulse on `cmp_b` has no effect.
- R6: Group g takes its trigger from the channel given by bits [2g+1:2g] of the select register (address 4). Pulses on any other channel do not change that group.
- R7: With the non-overlap bit at 1 (address 5, bit g for group g), a `cmp_a` pulse copies only the enabled bits whose next value is 0.
- R8: With the non-overlap bit at 1, a `cmp_b` pulse copies only the enabled bits whose next value is 1.
- R9: A bit whose next-data-enable is 0 is never changed by a trigger.
- R10: If a next-data write and a trigger fall in the same cycle, the transfer uses the old next-data value. The new value waits for the following trigger.
- R11: If an output data register write and a trigger fall in the same cycle, the bits being transferred take the next-data value and all other bits take the written value.
- R12: Group g covers pins [4g+3:4g]. Writes to addresses 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 next data, 1 output data, 2 enable, 3 direction, 4 trigger select, 5 non-overlap |
| wr_data | input | 16 | Write data |
| cmp_a | input | 4 | Compare-match A pulse, one bit per timer channel |
| cmp_b | input | 4 | Compare-match B pulse, one bit per timer channel |
| pin_out | output | 16 | Pattern pin values (output data register) |
| pin_oe | output | 16 | Pattern pin drive enables |

## Verification
Two things can happen to the pattern in the same clock cycle: a software register write and a compare-match transfer. The bench sets these up by raising the write strobe and a compare pulse on the same falling edge. It does this once for the next-data register and once for the output data register. The result is judged at the pins: the first transfer must carry the old staged value and the following trigger the new one, while a direct output write must lose only on the bits being transferred.

// File: rtl/tpo_pkg.sv
// Package: shared address map for the timing pattern output controller.
// Assumes a 3-bit register address; unused codes are decoded as no-ops.
package tpo_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_NEXT = 3'd0,
        REG_OUT  = 3'd1,
        REG_EN   = 3'd2,
        REG_DIR  = 3'd3,
        REG_SEL  = 3'd4,
        REG_NOV  = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/tpo_regfile.sv
// Module: control register file. Holds next data, enable, direction,
// trigger select and non-overlap bits, and decodes output-register writes.
// Assumes the write data word is wide enough for every select field.
module tpo_regfile
    import tpo_pkg::*;
#(
    parameter int unsigned GROUPS = 4,
    parameter int unsigned GW     = 4,
    parameter int unsigned CH_W   = 2,
    localparam int unsigned DW    = GROUPS * GW,
    localparam int unsigned SW    = GROUPS * CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     next_q,
    output logic [DW-1:0]     en_q,
    output logic [DW-1:0]     dir_q,
    output logic [SW-1:0]     sel_q,
    output logic [GROUPS-1:0] nov_q,
    output logic              out_we
);

    logic hit_next, hit_en, hit_dir, hit_sel, hit_nov;

    // Decode the write strobe into one hit per register.
    always_comb begin
        hit_next = wr_en && (wr_addr == REG_NEXT);
        hit_en   = wr_en && (wr_addr == REG_EN);
        hit_dir  = wr_en && (wr_addr == REG_DIR);
        hit_sel  = wr_en && (wr_addr == REG_SEL);
        hit_nov  = wr_en && (wr_addr == REG_NOV);
        out_we   = wr_en && (wr_addr == REG_OUT);
    end

    // Store the control registers; all clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            en_q   <= '0;
            dir_q  <= '0;
            sel_q  <= '0;
            nov_q  <= '0;
        end else begin
            if (hit_next) next_q <= wr_data;
            if (hit_en)   en_q   <= wr_data;
            if (hit_dir)  dir_q  <= wr_data;
            if (hit_sel)  sel_q  <= wr_data[SW-1:0];
            if (hit_nov)  nov_q  <= wr_data[GROUPS-1:0];
        end
    end

    // R12: unused addresses leave every register untouched.
    a_r12_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > REG_NOV) |=>
            ($stable(next_q) && $stable(en_q) && $stable(dir_q)
             && $stable(sel_q) && $stable(nov_q)));

endmodule

// File: rtl/tpo_trig_sel.sv
// Module: trigger source multiplexer. Picks the compare-match A/B pulse
// pair of one timer channel. Assumes pulses are one cycle, synchronous.
// A select code beyond the channel count yields no trigger.
module tpo_trig_sel #(
    parameter int unsigned CHANNELS = 4,
    parameter int unsigned CH_W     = 2
) (
    input  logic [CHANNELS-1:0] cmp_a,
    input  logic [CHANNELS-1:0] cmp_b,
    input  logic [CH_W-1:0]     sel,
    output logic                trig_a,
    output logic                trig_b
);

    // Route the selected channel's pulses to the group.
    always_comb begin
        trig_a = 1'b0;
        trig_b = 1'b0;
        for (int c = 0; c < CHANNELS; c++) begin
            if (sel == CH_W'(c)) begin
                trig_a = cmp_a[c];
                trig_b = cmp_b[c];
            end
        end
    end

endmodule

// File: rtl/tpo_group.sv
// Module: one pattern group. Owns its slice of the output data register.
// Computes which bits a trigger transfers, in normal or non-overlap mode.
// Assumes software writes apply first and transferred bits override them.
module tpo_group #(
    parameter int unsigned GW       = 4,
    parameter int unsigned CHANNELS = 4,
    parameter int unsigned CH_W     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] cmp_a,
    input  logic [CHANNELS-1:0] cmp_b,
    input  logic [CH_W-1:0]     sel,
    input  logic                nov,
    input  logic [GW-1:0]       next_d,
    input  logic [GW-1:0]       en,
    input  logic                out_we,
    input  logic [GW-1:0]       out_wdata,
    output logic [GW-1:0]       odr
);

    logic          trig_a, trig_b;
    logic [GW-1:0] xfer_mask;
    logic [GW-1:0] base_d;
    logic [GW-1:0] odr_d;

    tpo_trig_sel #(
        .CHANNELS (CHANNELS),
        .CH_W     (CH_W)
    ) u_sel (
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .sel    (sel),
        .trig_a (trig_a),
        .trig_b (trig_b)
    );

    // Build the transfer mask: all enabled bits on A, or split by direction.
    always_comb begin
        if (nov) begin
            xfer_mask = ({GW{trig_a}} & en & ~next_d)
                      | ({GW{trig_b}} & en &  next_d);
        end else begin
            xfer_mask = {GW{trig_a}} & en;
        end
    end

    // Merge software write and transfer into the next register value.
    always_comb begin
        base_d = out_we ? out_wdata : odr;
        odr_d  = (base_d & ~xfer_mask) | (next_d & xfer_mask);
    end

    // Hold the output data register slice.
    always_ff @(posedge clk) begin
        if (!rst_n) odr <= '0;
        else        odr <= odr_d;
    end

    // R9: disabled bits never move unless software writes them.
    a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_we |=> (((odr ^ $past(odr)) & ~$past(en)) == '0));

    // R5: in normal mode nothing moves without compare match A.
    a_r5_normal_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!nov && !trig_a && !out_we) |=> $stable(odr));

    // R7: compare match A in non-overlap mode produces no rising bit.
    a_r7_nov_a_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (nov && trig_a && !trig_b && !out_we) |=> ((odr & ~$past(odr)) == '0));

    // R8: compare match B in non-overlap mode produces no falling bit.
    a_r8_nov_b_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (nov && trig_b && !trig_a && !out_we) |=> (($past(odr) & ~odr) == '0));

endmodule

// File: rtl/tpo_ctrl.sv
// Module: timing pattern output controller top. Instantiates the register
// file and one group per pin nibble; drives pin values and drive enables.
// Assumes compare-match inputs are synchronous one-cycle pulses.
module tpo_ctrl
    import tpo_pkg::*;
#(
    parameter int unsigned GROUPS   = 4,
    parameter int unsigned GW       = 4,
    parameter int unsigned CHANNELS = 4,
    localparam int unsigned DW      = GROUPS * GW,
    localparam int unsigned CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [CHANNELS-1:0] cmp_a,
    input  logic [CHANNELS-1:0] cmp_b,
    output logic [DW-1:0]       pin_out,
    output logic [DW-1:0]       pin_oe
);

    logic [DW-1:0]          next_q, en_q, dir_q;
    logic [GROUPS*CH_W-1:0] sel_q;
    logic [GROUPS-1:0]      nov_q;
    logic                   out_we;
    logic [DW-1:0]          odr_all;

    tpo_regfile #(
        .GROUPS (GROUPS),
        .GW     (GW),
        .CH_W   (CH_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .next_q  (next_q),
        .en_q    (en_q),
        .dir_q   (dir_q),
        .sel_q   (sel_q),
        .nov_q   (nov_q),
        .out_we  (out_we)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        tpo_group #(
            .GW       (GW),
            .CHANNELS (CHANNELS),
            .CH_W     (CH_W)
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_a     (cmp_a),
            .cmp_b     (cmp_b),
            .sel       (sel_q[g*CH_W +: CH_W]),
            .nov       (nov_q[g]),
            .next_d    (next_q[g*GW +: GW]),
            .en        (en_q[g*GW +: GW]),
            .out_we    (out_we),
            .out_wdata (wr_data[g*GW +: GW]),
            .odr       (odr_all[g*GW +: GW])
        );
    end

    // Drive pins from the output register; enable needs direction and enable.
    always_comb begin
        pin_out = odr_all;
        pin_oe  = dir_q & en_q;
    end

    // R1: one cycle after reset, pins are undriven and zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0));

endmodule

// File: tb/tpo_ctrl_test.sv
module tpo_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  cmp_a = '0;
    logic [3:0]  cmp_b = '0;
    logic [15:0] pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tpo_ctrl uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: optional write plus optional compare pulses.
    task automatic step(bit we, logic [2:0] a, logic [15:0] d,
                        logic [3:0] pa, logic [3:0] pb);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; cmp_a = pa; cmp_b = pb;
        @(negedge clk);
        wr_en = 1'b0; cmp_a = '0; cmp_b = '0;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        step(1'b1, a, d, 4'h0, 4'h0);
    endtask

    task automatic t_reset();
        chk("R1 oe", pin_oe, 16'h0000);
        chk("R1 out", pin_out, 16'h0000);
    endtask

    task automatic t_enable_and_stage();
        wr(3'd1, 16'hA5A5);
        chk("R3 odr write", pin_out, 16'hA5A5);
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'h00FF);
        chk("R2 oe", pin_oe, 16'h00FF);
        chk("R3 shows odr", pin_out, 16'hA5A5);
        wr(3'd0, 16'h1234);
        chk("R4 staged", pin_out, 16'hA5A5);
    endtask

    task automatic t_normal();
        wr(3'd4, 16'h0000);
        step(1'b0, 3'd0, 16'h0, 4'h0, 4'h1);
        chk("R5 B ignored", pin_out, 16'hA5A5);
        step(1'b0, 3'd0, 16'h0, 4'h2, 4'h0);
        chk("R6 other channel", pin_out, 16'hA5A5);
        step(1'b0, 3'd0, 16'h0, 4'h1, 4'h0);
        chk("R5 A transfer", pin_out, 16'h1234);
    endtask

    task automatic t_select();
        wr(3'd4, 16'h00E4);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'hFFFF);
        step(1'b0, 3'd0, 16'h0, 4'h4, 4'h0);
        chk("R6 R12 group2 only", pin_out, 16'h0F00);
        step(1'b0, 3'd0, 16'h0, 4'h1, 4'h0);
        chk("R6 R12 group0", pin_out, 16'h0F0F);
    endtask

    task automatic t_disabled();
        wr(3'd4, 16'h0000);
        wr(3'd2, 16'h00FF);
        wr(3'd1, 16'hF0F0);
        wr(3'd0, 16'h0F0F);
        step(1'b0, 3'd0, 16'h0, 4'h1, 4'h0);
        chk("R9 disabled held", pin_out, 16'hF00F);
    endtask

    task automatic t_nonoverlap();
        wr(3'd2, 16'hFFFF);
        wr(3'd5, 16'h0001);
        wr(3'd1, 16'h0005);
        wr(3'd0, 16'h00A3);
        step(1'b0, 3'd0, 16'h0, 4'h1, 4'h0);
        chk("R7 A falls only", pin_out, 16'h00A1);
        step(1'b0, 3'd0, 16'h0, 4'h0, 4'h1);
        chk("R8 B rises only", pin_out, 16'h00A3);
        wr(3'd5, 16'h0000);
    endtask

    task automatic t_collide_next();
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h1111);
        step(1'b1, 3'd0, 16'h2222, 4'h1, 4'h0);
        chk("R10 old value", pin_out, 16'h1111);
        step(1'b0, 3'd0, 16'h0, 4'h1, 4'h0);
        chk("R10 new held", pin_out, 16'h2222);
    endtask

    task automatic t_collide_odr();
        wr(3'd2, 16'h000F);
        step(1'b1, 3'd1, 16'hFFFF, 4'h1, 4'h0);
        chk("R11 merge", pin_out, 16'hFFF2);
    endtask

    task automatic t_bad_addr();
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        chk("R12 unused oe", pin_oe, 16'h000F);
        step(1'b0, 3'd0, 16'h0, 4'h1, 4'h0);
        chk("R12 unused regs", pin_out, 16'hFFF2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_and_stage();
        t_normal();
        t_select();
        t_disabled();
        t_nonoverlap();
        t_collide_next();
        t_collide_odr();
        t_bad_addr();
        finish_run();
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule